// File: doc/BRIEF.md
# Receive Descriptor Scatter Engine with CRC

This block takes a received frame as a byte stream. It writes the frame into memory buffers that a ring of descriptors points to, and it appends a CRC-32 of the payload as four more bytes. Each descriptor is 8 bytes long. The first big-endian word holds the flags (upper 16 bits) and the length (lower 16 bits). The second word holds the buffer address. The engine uses only descriptors whose empty flag is set. When it fills one, it writes the first word back with empty cleared and the byte count stored. When it closes the final buffer of a frame, it also sets the last flag and the error flags. Software points the engine at the ring, sets a per-buffer byte cap and a frame-length limit, and then writes the receive-demand register to start reception.

The control flow is one state machine with nine states:

| State | Role |
|-------|------|
| `ST_OFF` | Receive is disabled. |
| `ST_CHK`, `ST_CHKW` | Read the flags word of the current descriptor and test its empty bit. |
| `ST_ADDR`, `ST_ADDRW` | Read the buffer address. |
| `ST_RUN` | Take payload bytes. |
| `ST_CRC` | Write the four CRC bytes. |
| `ST_CLOSE` | Write back the descriptor and step the ring. |
| `ST_DROP` | Discard the rest of a frame that ran out of descriptors. |

The transitions are:

- OFF→CHK on an accepted demand.
- CHK→CHKW always.
- CHKW→ADDR when the descriptor is empty.
- CHKW→OFF when it is not empty and no frame is in progress.
- CHKW→DROP when it is not empty inside a frame.
- ADDR→ADDRW always.
- ADDRW→RUN or CRC, returning to the phase that was interrupted.
- RUN→CLOSE when the buffer is full.
- RUN→CRC on the final payload byte.
- RUN→OFF when the controller enable input drops between frames.
- CRC→CLOSE when the buffer is full, or when the CRC is done or the size cap is reached.
- CLOSE→CHK always.
- DROP→CHK once the frame ends.

Memory reads return data one cycle after the request. A word access is big-endian. A byte write uses `mem_wdata[7:0]`.

Top module: `rx_scatter_engine`

## Requirements
- R1: After reset, receive is off: the demand register reads 0, `in_ready` is 0, and the control register reads 0x05EE0001.
- R2: Register selects are 0 = demand, 1 = control, 2 = buffer cap, 3 = ring base. Control keeps only the bits of 0x07FF003F. The buffer cap keeps only the bits of 0x7F0. The ring base has its two low bits forced to zero, and writing it also moves the current descriptor to that address.
- R3: A demand write with `mac_en` high while receive is off reads the current descriptor. Receive then turns on exactly when that descriptor's flag bit 15 (empty) is set. Reading the demand register returns bit 24 equal to the receive-on state.
- R4: Payload bytes go to consecutive addresses of the current buffer, at most the buffer-cap value per buffer. Each closed descriptor gets the number of bytes placed as its length, and bit 15 cleared.
- R5: After the payload, the engine writes four bytes of the final CRC-32, most significant byte first. The CRC uses the reflected 0x04C11DB7 polynomial, all-ones start and final inversion. These bytes count in the length and may be split across two buffers.
- R6: The last buffer of a frame gets flag bit 11 and a one-cycle `ev_frame` pulse. Every earlier buffer of the frame gives one `ev_buf` pulse.
- R7: A descriptor with flag bit 13 (wrap) is followed by the ring base. Any other descriptor is followed by the descriptor 8 bytes above it.
- R8: If the payload plus CRC exceeds 2032 bytes, only the first 2032 bytes are stored, and the last descriptor gets bits 0 (truncated) and 5 (length error).
- R9: If the stored size is larger than control bits 26:16, the last descriptor gets bit 5 only. A size equal to the limit sets no flag.
- R10: After every frame, the next descriptor's empty bit is tested again. If it is clear, receive turns off and `in_ready` goes low.
- R11: If a non-empty descriptor is reached in mid-frame, the rest of the frame is consumed without being stored. That descriptor is left untouched, no `ev_frame` is raised, and receive turns off.
- R12: A demand write while `mac_en` is low has no effect. When `mac_en` falls between frames, receive turns off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mac_en | input | 1 | Controller enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final payload byte of the frame |
| in_ready | output | 1 | Engine takes the byte at this edge |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_word | output | 1 | 32-bit access (1) or byte access (0) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| ev_buf | output | 1 | Non-final buffer closed |
| ev_frame | output | 1 | Final buffer of a frame closed |

## Verification
The hardest case to reach is a frame that runs out of descriptors partway through. That needs a descriptor ring with a non-empty entry right after the current one, together with a frame longer than a single buffer. Two cases are similar: CRC bytes split across a buffer boundary, and truncation that cuts into the CRC. Each needs the payload length chosen against the buffer cap or the 2032-byte ceiling.

To reach these cases, the bench re-arms the ring before each frame with a chosen mask of empty descriptors. It picks lengths that put the CRC boundary at exact offsets: 14 payload bytes with a 16-byte cap, and 2028, 2029 and 2040 bytes at the ceiling. A batch model then predicts every descriptor word and buffer byte from the total frame size. Random frames with random buffer caps also carry the ring across its wrap point.

// File: rtl/rxsg_pkg.sv
package rxsg_pkg;

    typedef enum logic [3:0] {
        ST_OFF,
        ST_CHK,
        ST_CHKW,
        ST_ADDR,
        ST_ADDRW,
        ST_RUN,
        ST_CRC,
        ST_CLOSE,
        ST_DROP
    } rx_state_e;

    localparam int FLG_EMPTY   = 15;
    localparam int FLG_WRAP    = 13;
    localparam int FLG_LAST    = 11;
    localparam int FLG_LEN_ERR = 5;
    localparam int FLG_TRUNC   = 0;

    localparam logic [1:0] SEL_DEMAND = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_BUFCAP = 2'd2;
    localparam logic [1:0] SEL_RING   = 2'd3;

    localparam logic [31:0] CTRL_KEEP   = 32'h07FF_003F;
    localparam logic [31:0] CTRL_INIT   = 32'h05EE_0001;
    localparam logic [31:0] BUFCAP_KEEP = 32'h0000_07F0;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;

endpackage

// File: rtl/rxsg_crc_step.sv
module rxsg_crc_step
    import rxsg_pkg::*;
(
    input  logic [31:0] crc_in,
    input  logic [7:0]  din,
    output logic [31:0] crc_out
);

    always_comb begin
        logic [31:0] c;
        c = crc_in ^ {24'h0, din};
        for (int b = 0; b < 8; b++) begin
            c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
        end
        crc_out = c;
    end

endmodule

// File: rtl/rxsg_regs.sv
module rxsg_regs
    import rxsg_pkg::*;
#(
    parameter int CNT_W  = 11,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              rx_on,
    output logic [31:0]       rdata,
    output logic [CNT_W-1:0]  len_limit,
    output logic [CNT_W-1:0]  buf_cap,
    output logic [ADDR_W-1:0] ring_base,
    output logic              demand,
    output logic              ring_load
);

    logic [31:0]       ctrl_q;
    logic [31:0]       cap_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_INIT;
            cap_q  <= '0;
            base_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_CTRL:   ctrl_q <= wdata & CTRL_KEEP;
                SEL_BUFCAP: cap_q  <= wdata & BUFCAP_KEEP;
                SEL_RING:   base_q <= {wdata[ADDR_W-1:2], 2'b00};
                default:    ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_DEMAND: rdata = {7'd0, rx_on, 24'd0};
            SEL_CTRL:   rdata = ctrl_q;
            SEL_BUFCAP: rdata = cap_q;
            default:    rdata = 32'(base_q);
        endcase
    end

    assign len_limit = ctrl_q[16 +: CNT_W];
    assign buf_cap   = cap_q[CNT_W-1:0];
    assign ring_base = base_q;
    assign demand    = wr && (sel == SEL_DEMAND);
    assign ring_load = wr && (sel == SEL_RING);

endmodule

// File: rtl/rx_scatter_engine.sv
module rx_scatter_engine
    import rxsg_pkg::*;
#(
    parameter int MAX_FRAME = 2032,
    parameter int CNT_W     = 11,
    parameter int ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mac_en,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              ev_buf,
    output logic              ev_frame
);

    localparam logic [CNT_W-1:0]  SIZE_CAP  = CNT_W'(MAX_FRAME);
    localparam logic [2:0]        CRC_DONE  = 3'd4;
    localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    rx_state_e         state, state_nx;
    logic [ADDR_W-1:0] cur_desc, buf_ptr, ring_base;
    logic [15:0]       dflags;
    logic [CNT_W-1:0]  buf_cnt, stored, len_limit, buf_cap;
    logic [31:0]       crc_q, crc_nx, crc_fin;
    logic [2:0]        crc_idx;
    logic              mid, crc_ph, trunc, rx_on, close_last;
    logic              demand, ring_load;
    logic              buf_full, room, take, tr_now, lg_now;
    logic [7:0]        crc_byte;
    logic [15:0]       close_flags;

    rxsg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .sel       (reg_addr),
        .wdata     (reg_wdata),
        .rx_on     (rx_on),
        .rdata     (reg_rdata),
        .len_limit (len_limit),
        .buf_cap   (buf_cap),
        .ring_base (ring_base),
        .demand    (demand),
        .ring_load (ring_load)
    );

    rxsg_crc_step u_crc (
        .crc_in  (crc_q),
        .din     (in_data),
        .crc_out (crc_nx)
    );

    assign crc_fin  = ~crc_q;
    assign buf_full = (buf_cnt >= buf_cap);
    assign room     = (stored < SIZE_CAP);
    assign take     = (state == ST_RUN) && in_valid && in_ready;
    assign tr_now   = trunc || (crc_idx != CRC_DONE);
    assign lg_now   = tr_now || (stored > len_limit);

    always_comb begin
        unique case (crc_idx[1:0])
            2'd0:    crc_byte = crc_fin[31:24];
            2'd1:    crc_byte = crc_fin[23:16];
            2'd2:    crc_byte = crc_fin[15:8];
            default: crc_byte = crc_fin[7:0];
        endcase
        close_flags = dflags;
        close_flags[FLG_EMPTY] = 1'b0;
        if (close_last) begin
            close_flags[FLG_LAST] = 1'b1;
            if (lg_now) close_flags[FLG_LEN_ERR] = 1'b1;
            if (tr_now) close_flags[FLG_TRUNC] = 1'b1;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (demand && mac_en) state_nx = ST_CHK;
            ST_CHK:   state_nx = ST_CHKW;
            ST_CHKW:  state_nx = mem_rdata[16+FLG_EMPTY] ? ST_ADDR : (mid ? ST_DROP : ST_OFF);
            ST_ADDR:  state_nx = ST_ADDRW;
            ST_ADDRW: state_nx = crc_ph ? ST_CRC : ST_RUN;
            ST_RUN: begin
                if (!mid && !mac_en)        state_nx = ST_OFF;
                else if (buf_full && room)  state_nx = ST_CLOSE;
                else if (take && in_last)   state_nx = ST_CRC;
            end
            ST_CRC: begin
                if (crc_idx == CRC_DONE || !room) state_nx = ST_CLOSE;
                else if (buf_full)                state_nx = ST_CLOSE;
            end
            ST_CLOSE: state_nx = ST_CHK;
            ST_DROP:  if (crc_ph || (in_valid && in_last)) state_nx = ST_CHK;
            default:  state_nx = ST_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        in_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_word  = 1'b0;
        mem_addr  = cur_desc;
        mem_wdata = '0;
        ev_buf    = 1'b0;
        ev_frame  = 1'b0;
        unique case (state)
            ST_CHK: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
            end
            ST_ADDR: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
                mem_addr = cur_desc + WORD_STEP;
            end
            ST_RUN: begin
                in_ready = !(buf_full && room) && (mid || mac_en);
                if (take && room) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_ptr + ADDR_W'(buf_cnt);
                    mem_wdata = {24'd0, in_data};
                end
            end
            ST_CRC: begin
                if (crc_idx != CRC_DONE && room && !buf_full) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = buf_ptr + ADDR_W'(buf_cnt);
                    mem_wdata = {24'd0, crc_byte};
                end
            end
            ST_CLOSE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = 1'b1;
                mem_wdata = {close_flags, {(16-CNT_W){1'b0}}, buf_cnt};
                ev_buf    = !close_last;
                ev_frame  = close_last;
            end
            ST_DROP: in_ready = !crc_ph;
            default: ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_desc   <= '0;
            buf_ptr    <= '0;
            dflags     <= '0;
            buf_cnt    <= '0;
            stored     <= '0;
            crc_q      <= '1;
            crc_idx    <= '0;
            mid        <= 1'b0;
            crc_ph     <= 1'b0;
            trunc      <= 1'b0;
            rx_on      <= 1'b0;
            close_last <= 1'b0;
        end else begin
            unique case (state)
                ST_CHKW: begin
                    dflags <= mem_rdata[31:16];
                    if (mem_rdata[16+FLG_EMPTY]) rx_on <= 1'b1;
                    else if (!mid)               rx_on <= 1'b0;
                end
                ST_ADDRW: begin
                    buf_ptr <= mem_rdata[ADDR_W-1:0];
                    buf_cnt <= '0;
                end
                ST_RUN: begin
                    if (!mid && !mac_en) rx_on <= 1'b0;
                    if (buf_full && room) close_last <= 1'b0;
                    if (take) begin
                        mid   <= 1'b1;
                        crc_q <= crc_nx;
                        if (room) begin
                            buf_cnt <= buf_cnt + 1'b1;
                            stored  <= stored + 1'b1;
                        end else begin
                            trunc <= 1'b1;
                        end
                        if (in_last) begin
                            crc_ph  <= 1'b1;
                            crc_idx <= '0;
                        end
                    end
                end
                ST_CRC: begin
                    close_last <= (crc_idx == CRC_DONE) || !room;
                    if (crc_idx != CRC_DONE && room && !buf_full) begin
                        crc_idx <= crc_idx + 1'b1;
                        buf_cnt <= buf_cnt + 1'b1;
                        stored  <= stored + 1'b1;
                    end
                end
                ST_CLOSE: begin
                    cur_desc <= dflags[FLG_WRAP] ? ring_base : cur_desc + DESC_STEP;
                    if (close_last) begin
                        mid    <= 1'b0;
                        crc_ph <= 1'b0;
                        stored <= '0;
                        trunc  <= 1'b0;
                        crc_q  <= '1;
                    end
                end
                ST_DROP: begin
                    if (crc_ph || (in_valid && in_last)) begin
                        mid    <= 1'b0;
                        crc_ph <= 1'b0;
                        stored <= '0;
                        trunc  <= 1'b0;
                        crc_q  <= '1;
                    end
                end
                default: ;
            endcase
            if (ring_load) cur_desc <= {reg_wdata[ADDR_W-1:2], 2'b00};
        end
    end

    // R10 / R11: no byte is ever taken while receive is off
    a_r10_ready_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> rx_on);

    // R4: a data byte is written only while the buffer still has room
    a_r4_buf_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_word) |-> (buf_cnt < buf_cap));

    // R8: stored size never passes the ceiling
    a_r8_size_cap: assert property (@(posedge clk) disable iff (!rst_n)
        stored <= SIZE_CAP);

    // R7: after a descriptor close the pointer is either the ring base or 8 bytes on
    a_r7_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSE && !ring_load) |=>
            (cur_desc == ring_base || cur_desc == $past(cur_desc) + DESC_STEP));

    // R12: with receive off the engine issues no memory traffic
    a_r12_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !mem_req);

endmodule

// File: tb/tb_rx_scatter_engine.sv
module tb_rx_scatter_engine;

    localparam int NDESC     = 8;
    localparam int RING      = 32'h1000;
    localparam int BUF_BASE  = 32'h2000;
    localparam int BUF_SPAN  = 32'h800;
    localparam int MAXF      = 2032;

    logic        clk = 1'b0;
    logic        rst_n, mac_en, reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        in_valid, in_last, in_ready;
    logic [7:0]  in_data;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        ev_buf, ev_frame;

    always #5 clk = ~clk;

    rx_scatter_engine dut (
        .clk(clk), .rst_n(rst_n), .mac_en(mac_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ev_buf(ev_buf), .ev_frame(ev_frame)
    );

    logic [7:0] mem [0:32767];
    logic [7:0] pl  [0:2099];
    logic [7:0] full[0:2103];
    int checks = 0, fails = 0;
    int nbuf = 0, nfrm = 0;
    int midx = 0;
    int mbs = 64;
    int limit = 32'h5EE;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                if (mem_word) begin
                    mem[mem_addr[14:0]]      <= mem_wdata[31:24];
                    mem[mem_addr[14:0] + 1]  <= mem_wdata[23:16];
                    mem[mem_addr[14:0] + 2]  <= mem_wdata[15:8];
                    mem[mem_addr[14:0] + 3]  <= mem_wdata[7:0];
                end else begin
                    mem[mem_addr[14:0]] <= mem_wdata[7:0];
                end
            end else begin
                mem_rdata <= {mem[mem_addr[14:0]], mem[mem_addr[14:0] + 1],
                              mem[mem_addr[14:0] + 2], mem[mem_addr[14:0] + 3]};
            end
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (ev_buf)   nbuf = nbuf + 1;
            if (ev_frame) nfrm = nfrm + 1;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] rd_word(input int a);
        return {mem[a], mem[a+1], mem[a+2], mem[a+3]};
    endfunction

    task automatic wr_word(input int a, input logic [31:0] w);
        {mem[a], mem[a+1], mem[a+2], mem[a+3]} = w;
    endtask

    function automatic logic [15:0] base_flags(input int idx, input bit empty);
        return (empty ? 16'h8000 : 16'h0) | ((idx == NDESC-1) ? 16'h2000 : 16'h0);
    endfunction

    task automatic arm_ring(input logic [NDESC-1:0] mask);
        for (int i = 0; i < NDESC; i++) begin
            wr_word(RING + 8*i, {base_flags(i, mask[i]), 16'h0});
            wr_word(RING + 8*i + 4, BUF_BASE + i*BUF_SPAN);
            for (int j = 0; j < BUF_SPAN; j++) mem[BUF_BASE + i*BUF_SPAN + j] = 8'hEE;
        end
    endtask

    function automatic logic [31:0] crc_of(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, pl[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic push(input logic [7:0] d, input bit last);
        bit acc;
        in_valid = 1'b1; in_data = d; in_last = last;
        forever begin
            acc = in_ready;
            @(negedge clk);
            if (acc) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic run_frame(input string req, input int len, input logic [NDESC-1:0] mask);
        logic [31:0] rv, c;
        int total, stored, pos, idx, chunk, nb, bad, b0, f0;
        bit tr, lg, last, dropped;
        logic [15:0] ef;
        arm_ring(mask);
        reg_read(2'd0, rv);
        if (rv[24] == 1'b0) begin
            reg_write(2'd0, 32'h0);
            repeat (8) @(negedge clk);
        end
        for (int i = 0; i < len; i++) pl[i] = 8'($urandom);
        c = crc_of(len);
        for (int i = 0; i < len; i++) full[i] = pl[i];
        full[len] = c[31:24]; full[len+1] = c[23:16]; full[len+2] = c[15:8]; full[len+3] = c[7:0];
        total  = len + 4;
        stored = (total > MAXF) ? MAXF : total;
        tr     = (total > MAXF);
        lg     = tr || (stored > limit);
        b0 = nbuf; f0 = nfrm;
        for (int i = 0; i < len; i++) push(pl[i], i == len - 1);
        repeat (40) @(negedge clk);
        pos = 0; idx = midx; nb = 0; dropped = 0;
        while (pos < stored) begin
            if (!mask[idx]) begin dropped = 1; break; end
            chunk = (stored - pos > mbs) ? mbs : stored - pos;
            last  = (pos + chunk == stored);
            ef = base_flags(idx, 1'b0);
            if (last) ef = ef | 16'h0800 | (lg ? 16'h0020 : 16'h0) | (tr ? 16'h0001 : 16'h0);
            rv = rd_word(RING + 8*idx);
            check(rv == {ef, 16'(chunk)}, req, $sformatf("descriptor %0d word", idx), rv, {ef, 16'(chunk)});
            bad = 0;
            for (int j = 0; j < chunk; j++)
                if (mem[BUF_BASE + idx*BUF_SPAN + j] !== full[pos + j]) bad++;
            if (mem[BUF_BASE + idx*BUF_SPAN + chunk] !== 8'hEE) bad++;
            check(bad == 0, req, $sformatf("buffer %0d byte mismatches", idx), bad, 0);
            pos += chunk;
            if (!last) nb++;
            idx = (idx == NDESC-1) ? 0 : idx + 1;
        end
        check(nbuf - b0 == nb, "R6", "buffer event count", nbuf - b0, nb);
        reg_read(2'd0, rv);
        if (dropped) begin
            check(nfrm == f0, "R11", "frame events after drop", nfrm - f0, 0);
            rv = rd_word(RING + 8*idx);
            check(rv == {base_flags(idx, 1'b0), 16'h0}, "R11", "blocking descriptor untouched",
                  rv, {base_flags(idx, 1'b0), 16'h0});
            reg_read(2'd0, rv);
            check(rv == 32'h0, "R11", "receive off after drop", rv, 32'h0);
        end else begin
            check(nfrm - f0 == 1, "R6", "frame event count", nfrm - f0, 1);
            check(rv[24] == mask[idx], "R10", "receive state after frame", 32'(rv[24]), 32'(mask[idx]));
        end
        midx = idx;
    endtask

    initial begin
        logic [31:0] rv;
        void'($urandom(32'd2024));
        for (int i = 0; i < 32768; i++) mem[i] = 8'h00;
        rst_n = 1'b0; mac_en = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        in_valid = 1'b0; in_data = '0; in_last = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, rv); check(rv == 0, "R1", "demand read after reset", rv, 0);
        reg_read(2'd1, rv); check(rv == 32'h05EE0001, "R1", "control reset value", rv, 32'h05EE0001);
        check(in_ready == 1'b0, "R1", "in_ready after reset", 32'(in_ready), 0);

        // R2 register masks
        reg_write(2'd1, 32'hFFFF_FFFF); reg_read(2'd1, rv);
        check(rv == 32'h07FF003F, "R2", "control mask", rv, 32'h07FF003F);
        reg_write(2'd1, 32'h05EE0001);
        reg_write(2'd2, 32'hFFFF_FFFF); reg_read(2'd2, rv);
        check(rv == 32'h7F0, "R2", "buffer cap mask", rv, 32'h7F0);
        reg_write(2'd3, RING | 3); reg_read(2'd3, rv);
        check(rv == RING, "R2", "ring base low bits", rv, RING);

        // R12 demand ignored while controller disabled
        arm_ring('1);
        mbs = 64; reg_write(2'd2, mbs);
        reg_write(2'd0, 0); repeat (8) @(negedge clk);
        reg_read(2'd0, rv); check(rv == 0, "R12", "demand with mac_en low", rv, 0);

        // R3 demand enables receive
        mac_en = 1'b1;
        reg_write(2'd0, 0); repeat (8) @(negedge clk);
        reg_read(2'd0, rv); check(rv == 32'h0100_0000, "R3", "demand read when on", rv, 32'h0100_0000);

        // R4 R5 R7 random frames across the ring wrap
        for (int k = 0; k < 14; k++) begin
            mbs = 16 * (4 + ($urandom % 13));
            reg_write(2'd2, mbs);
            run_frame("R4", 1 + ($urandom % 300), '1);
        end

        // R5 CRC straddling a buffer boundary
        mbs = 16; reg_write(2'd2, mbs);
        run_frame("R5", 14, '1);
        run_frame("R5", 13, '1);

        // R9 soft length limit, above and at the limit
        limit = 100; reg_write(2'd1, (100 << 16) | 1);
        mbs = 64; reg_write(2'd2, mbs);
        run_frame("R9", 97, '1);
        run_frame("R9", 96, '1);

        // R8 truncation at the ceiling
        limit = 32'h7FF; reg_write(2'd1, 32'h07FF0001);
        mbs = 32'h7F0; reg_write(2'd2, mbs);
        run_frame("R8", 2028, '1);
        run_frame("R8", 2029, '1);
        run_frame("R8", 2040, '1);

        // R10 next descriptor not empty: receive turns off
        mbs = 64; reg_write(2'd2, mbs);
        run_frame("R10", 60, 8'(1 << midx));
        @(negedge clk);
        check(in_ready == 1'b0, "R10", "in_ready after ring exhausted", 32'(in_ready), 0);

        // R3 demand while current descriptor not empty keeps receive off
        reg_write(2'd0, 0); repeat (8) @(negedge clk);
        reg_read(2'd0, rv); check(rv == 0, "R3", "demand on non-empty descriptor", rv, 0);

        // R11 drop in mid-frame
        mbs = 32; reg_write(2'd2, mbs);
        run_frame("R11", 100, 8'(1 << midx));
        reg_write(2'd3, RING); midx = 0;

        // R12 controller disable between frames
        arm_ring('1);
        reg_write(2'd0, 0); repeat (8) @(negedge clk);
        mac_en = 1'b0; repeat (4) @(negedge clk);
        reg_read(2'd0, rv); check(rv == 0, "R12", "receive off after mac_en drop", rv, 0);
        mac_en = 1'b1;
        run_frame("R4", 40, '1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule